// File: doc/BRIEF.md
# Read/write drain mode arbiter

This block sits beside the read and write burst queues of a single-channel memory controller and decides which direction the shared data bus serves. Each queue entry stands for one memory burst, so both occupancy inputs count bursts. The arbiter holds read mode by default. It moves to write mode when the write queue grows past an upper mark, even while reads are waiting. It also moves to write mode when the read queue is empty and the write queue has reached a lower mark.

A write drain does not end as soon as occupancy dips. A minimum number of write bursts must be issued first. The drain ends early only if the write queue runs dry. Once the minimum is met, the block goes back to reads when write occupancy falls under the lower mark.

Every change of direction loads a turnaround down-counter, and the grant permission stays low until that counter reaches zero. One gap length applies to read-to-write changes and another to write-to-read changes.

Top module: `rw_drain_arbiter`

## Requirements
- R1: After reset, `mode_wr` is 0 (read mode) and `grant_ok` is 1.
- R2: The marks are computed at elaboration as integer burst counts, rounded down: upper mark = WQ_DEPTH*HI_PCT/100 and lower mark = WQ_DEPTH*LO_PCT/100. With the defaults these are 54 and 32.
- R3: In read mode, if `wr_count` is at or above the upper mark at a clock edge, `mode_wr` is 1 from that edge on. This holds whatever the value of `rd_count`.
- R4: In read mode, if `rd_count` is 0 and `wr_count` is at or above the lower mark at a clock edge, `mode_wr` becomes 1 at that edge.
- R5: In read mode, `mode_wr` stays 0 in two cases: `wr_count` is below the upper mark while reads are pending, or `wr_count` is below the lower mark.
- R6: In write mode, while fewer than MIN_WR write bursts have been issued since the drain began, `mode_wr` stays 1 unless `wr_count` is 0. A write burst is counted when `issue_vld`=1 and `issue_is_wr`=1 at an edge in write mode. Read bursts (`issue_is_wr`=0) do not count.
- R7: In write mode, `wr_count`=0 at an edge returns `mode_wr` to 0 at that edge, even before the minimum is reached.
- R8: In write mode, once the minimum is met, the block returns to read mode at the first edge where `wr_count` is below the lower mark. While `wr_count` stays at or above the lower mark, it remains in write mode.
- R9: After a change from read to write mode, `grant_ok` is 0 for exactly RTW_CYC cycles, then 1.
- R10: After a change from write to read mode, `grant_ok` is 0 for exactly WTR_CYC cycles, then 1.
- R11: A direction decision uses the inputs sampled at a clock edge, and `mode_wr` changes at that same edge, one register deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_count | input | $clog2(RQ_DEPTH+1) | Read queue occupancy in bursts |
| wr_count | input | $clog2(WQ_DEPTH+1) | Write queue occupancy in bursts |
| issue_vld | input | 1 | A burst was issued this cycle |
| issue_is_wr | input | 1 | Direction of the issued burst, 1 = write |
| mode_wr | output | 1 | Current bus direction, 1 = write, 0 = read |
| grant_ok | output | 1 | Issue permitted; 0 during turnaround |

## Verification
A wrong drain count shows at `mode_wr` within one cycle of the point where the minimum should have been met. Depending on the fault, the drain either ends early while occupancy is low or lasts past the 16th write. A wrong mark or a swapped comparison shows as a mode change one edge too early or too late around the 31/32 and 53/54 occupancy boundaries. A bad turnaround counter shows at `grant_ok` within RTW_CYC or WTR_CYC cycles of each change.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;
   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } bus_dir_e;

   function automatic int pct_of(input int depth, input int pct);
      return (depth * pct) / 100;
   endfunction

   function automatic int width_for(input int maxval);
      return (maxval < 1) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/rwarb_drain_count.sv
module rwarb_drain_count #(
   parameter int MIN_WR = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_wr,
   input  logic to_wr,
   input  logic issue_vld,
   input  logic issue_is_wr,
   output logic min_met
);
   localparam int CW = rwarb_pkg::width_for(MIN_WR);
   localparam logic [CW-1:0] MIN_W = CW'(MIN_WR);

   logic [CW-1:0] cnt_q;
   logic          wr_hit;

   assign wr_hit = mode_wr && issue_vld && issue_is_wr;

   generate
      if (MIN_WR == 1) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)      cnt_q <= '0;
            else if (to_wr)  cnt_q <= '0;
            else if (wr_hit) cnt_q <= 1'b1;
         end
      end else begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (to_wr)                    cnt_q <= '0;
            else if (wr_hit && cnt_q < MIN_W)  cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   assign min_met = (cnt_q >= MIN_W);

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= MIN_W);
   assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      to_wr |=> !min_met);
endmodule

// File: rtl/rwarb_gap_timer.sv
module rwarb_gap_timer #(
   parameter int RTW_CYC = 2,
   parameter int WTR_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic to_wr,
   input  logic to_rd,
   output logic grant_ok
);
   localparam int GMAX = (RTW_CYC > WTR_CYC) ? RTW_CYC : WTR_CYC;
   localparam int GW   = rwarb_pkg::width_for(GMAX);
   localparam logic [GW-1:0] RTW_W = GW'(RTW_CYC);
   localparam logic [GW-1:0] WTR_W = GW'(WTR_CYC);

   logic [GW-1:0] gap_q;
   logic [GW-1:0] load_val;

   generate
      if (RTW_CYC == WTR_CYC) begin : g_same
         assign load_val = RTW_W;
      end else begin : g_split
         assign load_val = to_wr ? RTW_W : WTR_W;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                 gap_q <= '0;
      else if (to_wr || to_rd)    gap_q <= load_val;
      else if (gap_q != '0)       gap_q <= gap_q - 1'b1;
   end

   assign grant_ok = (gap_q == '0);

   assert_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_wr && to_rd));

   generate
      if (RTW_CYC > 0) begin : g_chk_rtw
         assert_rtw_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
            to_wr |=> !grant_ok);
      end
      if (WTR_CYC > 0) begin : g_chk_wtr
         assert_wtr_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            to_rd |=> !grant_ok);
      end
   endgenerate
endmodule

// File: rtl/rwarb_mode_fsm.sv
module rwarb_mode_fsm #(
   parameter int RCW    = 6,
   parameter int WCW    = 7,
   parameter int HI_THR = 54,
   parameter int LO_THR = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RCW-1:0] rd_count,
   input  logic [WCW-1:0] wr_count,
   input  logic           min_met,
   output logic           mode_wr,
   output logic           to_wr,
   output logic           to_rd
);
   import rwarb_pkg::*;

   localparam logic [WCW-1:0] HI_W = WCW'(HI_THR);
   localparam logic [WCW-1:0] LO_W = WCW'(LO_THR);

   bus_dir_e dir_q;
   logic     wr_urgent, wr_idle_ok, wr_empty, wr_low;

   assign wr_urgent  = (wr_count >= HI_W);
   assign wr_idle_ok = (rd_count == '0) && (wr_count >= LO_W);
   assign wr_empty   = (wr_count == '0);
   assign wr_low     = (wr_count < LO_W);

   always_comb begin
      to_wr = 1'b0;
      to_rd = 1'b0;
      unique case (dir_q)
         DIR_RD: to_wr = wr_urgent || wr_idle_ok;
         DIR_WR: to_rd = wr_empty || (min_met && wr_low);
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     dir_q <= DIR_RD;
      else if (to_wr) dir_q <= DIR_WR;
      else if (to_rd) dir_q <= DIR_RD;
   end

   assign mode_wr = (dir_q == DIR_WR);

   assert_hi_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && wr_count >= HI_W) |=> mode_wr);
   assert_idle_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && rd_count == '0 && wr_count >= LO_W) |=> mode_wr);
   assert_stay_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && wr_count < LO_W) |=> !mode_wr);
   assert_min_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !min_met && wr_count != '0) |=> mode_wr);
   assert_empty_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && wr_count == '0) |=> !mode_wr);
   assert_low_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && min_met && wr_count < LO_W) |=> !mode_wr);
endmodule

// File: rtl/rw_drain_arbiter.sv
module rw_drain_arbiter #(
   parameter int WQ_DEPTH = 64,
   parameter int RQ_DEPTH = 32,
   parameter int HI_PCT   = 85,
   parameter int LO_PCT   = 50,
   parameter int MIN_WR   = 16,
   parameter int RTW_CYC  = 2,
   parameter int WTR_CYC  = 6,
   localparam int RCW = $clog2(RQ_DEPTH + 1),
   localparam int WCW = $clog2(WQ_DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RCW-1:0] rd_count,
   input  logic [WCW-1:0] wr_count,
   input  logic           issue_vld,
   input  logic           issue_is_wr,
   output logic           mode_wr,
   output logic           grant_ok
);
   localparam int HI_THR = rwarb_pkg::pct_of(WQ_DEPTH, HI_PCT);
   localparam int LO_THR = rwarb_pkg::pct_of(WQ_DEPTH, LO_PCT);

   generate
      if (WQ_DEPTH < 1 || RQ_DEPTH < 1) begin : g_bad_depth
         $error("queue depths must be at least 1");
      end
      if (LO_THR < 1) begin : g_bad_lo
         $error("lower mark must be at least one burst");
      end
      if (HI_THR < LO_THR || HI_PCT > 100) begin : g_bad_hi
         $error("upper mark must lie between lower mark and depth");
      end
      if (MIN_WR < 1 || RTW_CYC < 0 || WTR_CYC < 0) begin : g_bad_cnt
         $error("minimum drain must be positive and gaps non-negative");
      end
   endgenerate

   logic min_met, to_wr, to_rd;

   rwarb_mode_fsm #(
      .RCW(RCW), .WCW(WCW), .HI_THR(HI_THR), .LO_THR(LO_THR)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
      .min_met(min_met), .mode_wr(mode_wr), .to_wr(to_wr), .to_rd(to_rd)
   );

   rwarb_drain_count #(.MIN_WR(MIN_WR)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .to_wr(to_wr),
      .issue_vld(issue_vld), .issue_is_wr(issue_is_wr), .min_met(min_met)
   );

   rwarb_gap_timer #(.RTW_CYC(RTW_CYC), .WTR_CYC(WTR_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n), .to_wr(to_wr), .to_rd(to_rd),
      .grant_ok(grant_ok)
   );
endmodule

// File: tb/rw_drain_arbiter_bench.sv
module rw_drain_arbiter_bench;
   localparam int HI  = 54;
   localparam int LO  = 32;
   localparam int MIN = 16;
   localparam int RTW = 2;
   localparam int WTR = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] rd_count = '0;
   logic [6:0] wr_count = '0;
   logic       issue_vld = 1'b0;
   logic       issue_is_wr = 1'b0;
   logic       mode_wr, grant_ok;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit m_wr;
   int m_gap, m_cnt;

   always #2.5 clk = ~clk;

   rw_drain_arbiter u_rw_drain_arbiter (
      .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
      .issue_vld(issue_vld), .issue_is_wr(issue_is_wr),
      .mode_wr(mode_wr), .grant_ok(grant_ok)
   );

   function automatic bit f_enter(bit wr, int rd, int wc);
      return !wr && (wc >= HI || (rd == 0 && wc >= LO));
   endfunction
   function automatic bit f_leave(bit wr, int wc, int cnt);
      return wr && (wc == 0 || (cnt >= MIN && wc < LO));
   endfunction

   always @(posedge clk) begin
      bit en, lv;
      en = f_enter(m_wr, int'(rd_count), int'(wr_count));
      lv = f_leave(m_wr, int'(wr_count), m_cnt);
      if (!rst_n) begin
         m_wr <= 1'b0; m_gap <= 0; m_cnt <= 0;
      end else begin
         if (en) m_wr <= 1'b1; else if (lv) m_wr <= 1'b0;
         m_gap <= en ? RTW : lv ? WTR : (m_gap > 0 ? m_gap - 1 : 0);
         if (en) m_cnt <= 0;
         else if (m_wr && issue_vld && issue_is_wr && m_cnt < MIN) m_cnt <= m_cnt + 1;
      end
   end

   task automatic chk(string tag, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, int rd, int wc, bit iv, bit iw);
      rd_count = 6'(rd); wr_count = 7'(wc); issue_vld = iv; issue_is_wr = iw;
      @(negedge clk);
      chk(tag, mode_wr, m_wr, "mode_wr");
      chk(tag, grant_ok, (m_gap == 0), "grant_ok");
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_count = 6'd5; wr_count = 7'd0;
      @(negedge clk);
      chk("R1", mode_wr, 1'b0, "reset mode");
      chk("R1", grant_ok, 1'b1, "reset grant");

      // R5: just under upper mark with reads pending, and under lower mark with reads empty
      repeat (3) step("R5", 5, HI - 1, 0, 0);
      chk("R5", mode_wr, 1'b0, "below upper mark");
      repeat (3) step("R5", 0, LO - 1, 0, 0);
      chk("R5", mode_wr, 1'b0, "below lower mark");

      // R3 and R2: upper mark 54 forces writes with reads pending; R11 one edge
      step("R3", 5, HI, 0, 0);
      chk("R3", mode_wr, 1'b1, "forced write");
      chk("R9", grant_ok, 1'b0, "rtw gap first");
      step("R9", 5, HI, 0, 0);
      chk("R9", grant_ok, 1'b0, "rtw gap second");
      step("R9", 5, HI, 0, 0);
      chk("R9", grant_ok, 1'b1, "rtw gap over");

      // R6: occupancy drops below lower mark, hold until 16 writes; reads do not count
      step("R6", 5, 10, 1, 0);
      for (int i = 0; i < MIN - 1; i++) step("R6", 5, 10, 1, 1);
      chk("R6", mode_wr, 1'b1, "held before min");
      step("R6", 5, 10, 1, 1);
      chk("R6", mode_wr, 1'b1, "min just met");
      step("R8", 5, 10, 0, 0);
      chk("R8", mode_wr, 1'b0, "exit below lower");
      for (int i = 0; i < WTR; i++) begin
         chk("R10", grant_ok, 1'b0, "wtr gap");
         step("R10", 5, 10, 0, 0);
      end
      chk("R10", grant_ok, 1'b1, "wtr gap over");

      // R4: idle reads and lower mark 32
      step("R4", 0, LO, 0, 0);
      chk("R4", mode_wr, 1'b1, "idle entry");
      // R7: empties early
      step("R7", 0, 0, 0, 0);
      chk("R7", mode_wr, 1'b0, "empty exit");
      repeat (WTR) step("R10", 3, 0, 0, 0);

      // R8: min met but occupancy at lower mark stays in write
      step("R4", 0, LO, 0, 0);
      for (int i = 0; i < MIN + 2; i++) step("R8", 3, LO, 1, 1);
      repeat (3) step("R8", 3, LO, 0, 0);
      chk("R8", mode_wr, 1'b1, "stay at lower mark");
      step("R8", 3, LO - 1, 0, 0);
      chk("R8", mode_wr, 1'b0, "exit under lower mark");

      // random mix checked against bench model (R3 R4 R6 R7 R8 R9 R10 R11)
      for (int i = 0; i < 4000; i++) begin
         int rd, wc;
         rd = ($urandom % 3 == 0) ? 0 : int'($urandom % 33);
         case ($urandom % 4)
            0: wc = 0;
            1: wc = LO - 1 + int'($urandom % 3);
            2: wc = HI - 1 + int'($urandom % 3);
            default: wc = int'($urandom % 65);
         endcase
         step("R11", rd, wc, 1'($urandom), 1'($urandom % 4 != 0));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule